// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital core of a processor supervisor. An external comparator supplies a flag, already synchronous to the clock, that is true while the supply sits below its reset threshold. The block turns that flag and a watchdog strobe from the processor into a pair of complementary reset outputs. Reset asserts as soon as the supply-low flag is seen. It is then held for a fixed hold time once the flag clears. A dip during the hold time starts the hold over.

The watchdog strobe is asynchronous, so it goes through a synchronizer before its edges are detected. Rising and falling edges both count as a kick. The watchdog counts only while reset is released. If it goes a whole watchdog period without a kick, it raises a reset that lasts exactly one hold time. A separate disable input stands for a watchdog pin left floating, and it stops the watchdog from ever expiring. Both times are parameters in clock ticks.

Top module: `supv_reset_ctrl`

## Requirements
- R1: Reset (rst_out_n low) asserts after the first clock edge that samples supply_low high. It stays asserted after every edge that samples supply_low high.
- R2: After the last edge that samples supply_low high, reset stays asserted for RST_TICKS-1 further edges. It releases at exactly the RST_TICKS-th edge after that last edge.
- R3: If supply_low is sampled high again before the hold completes, the hold count restarts. Release then follows R2 measured from the new last high edge.
- R4: With no kick and the watchdog enabled, reset reasserts at exactly the WD_TICKS-th edge after release. It is then held for exactly RST_TICKS edges.
- R5: A rising or a falling change on wd_in is a kick. A change applied before clock edge e clears the watchdog count at edge e+2, two synchronizer stages plus one edge register. The next expiry then comes WD_TICKS edges after that clearing edge.
- R6: While reset is asserted, the watchdog count is held at zero and wd_in changes have no effect. After every release the full WD_TICKS period applies, however long reset was held.
- R7: While wd_off is high, the watchdog never expires and reset stays released.
- R8: rst_out is always the exact inverse of rst_out_n.
- R9: While rst_n is low, rst_out_n is low and rst_out is high. After rst_n releases, reset output releases at the RST_TICKS-th edge, provided supply_low stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| supply_low | input | 1 | Synchronous flag, high while the supply is below threshold |
| wd_in | input | 1 | Asynchronous watchdog strobe from the processor |
| wd_off | input | 1 | High disables the watchdog (models a floating strobe pin) |
| rst_out_n | output | 1 | Active-low reset to the processor |
| rst_out | output | 1 | Active-high reset, inverse of rst_out_n |

## Verification
The assertions assume that supply_low is already synchronous to clk, so it can be used the same cycle it is sampled. They also assume that wd_off changes only from clocked logic. wd_in alone may change at any time, since it passes through the synchronizer before any assertion sees it. The stimulus changes every input on the falling clock edge, so each input value is settled well before the rising edge that samples it. Watchdog kicks are spaced closer together than the watchdog period whenever expiry is not the intent.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // width of a counter that must hold 0 .. n-1, never less than one bit
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic toggle
);
  logic [STAGES-1:0] sreg_q, sreg_d;
  logic              last_q, last_d;

  always_comb begin
    sreg_d = {sreg_q[STAGES-2:0], din};
    last_d = sreg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      last_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      last_q <= last_d;
    end
  end

  assign toggle = sreg_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int WD_TICKS = 1600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic off,
  input  logic kick,
  output logic expire
);
  localparam int CW = supv_pkg::cnt_w(WD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clr, cnt_en;

  assign expire = !hold && !off && !kick && (cnt_q == LAST);

  always_comb begin
    clr    = hold || off || kick || expire;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    cnt_en = clr ? (cnt_q != '0) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: count frozen at zero while reset is active
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
  // R5: a kick clears the count
  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));
  // R7: disabled watchdog never advances
  a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (cnt_q == '0));
endmodule

// File: rtl/supv_hold.sv
module supv_hold #(
  parameter int RST_TICKS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic wd_expire,
  output logic active
);
  localparam int CW = supv_pkg::cnt_w(RST_TICKS);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cause, upd_en;

  always_comb begin
    cause = supply_low || wd_expire;
    act_d = act_q;
    cnt_d = cnt_q;
    if (cause) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    upd_en = cause || act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;

  // R1: supply low forces reset on the next edge
  a_r1_assert: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> active);
  // R3: a new dip restarts the hold count
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (cnt_q == '0));
  // R2: release only after a full count with the supply good
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(cnt_q) == LAST && !$past(supply_low)));
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter int RST_TICKS   = 200000,
  parameter int WD_TICKS    = 1600000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic wd_in,
  input  logic wd_off,
  output logic rst_out_n,
  output logic rst_out
);
  logic wd_edge, wd_expire, hold_act;

  supv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (wd_in),
    .toggle (wd_edge)
  );

  supv_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold_act),
    .off    (wd_off),
    .kick   (wd_edge),
    .expire (wd_expire)
  );

  supv_hold #(.RST_TICKS(RST_TICKS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_low (supply_low),
    .wd_expire  (wd_expire),
    .active     (hold_act)
  );

  assign rst_out_n = ~hold_act;
  assign rst_out   = hold_act;

  // R4: watchdog expiry drives the reset outputs on the next edge
  a_r4_expire_resets: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (!rst_out_n && rst_out));
  // R7: disabled watchdog leaves a released reset released
  a_r7_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_off && rst_out_n && !supply_low) |=> rst_out_n);
endmodule

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;
  localparam int R = 20;
  localparam int W = 50;

  logic clk, rst_n, supply_low, wd_in, wd_off;
  logic rst_out_n, rst_out;

  supv_reset_ctrl #(.RST_TICKS(R), .WD_TICKS(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wd_in(wd_in),
    .wd_off(wd_off), .rst_out_n(rst_out_n), .rst_out(rst_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  exp_n;
    string tag;
  } item_t;
  item_t q[$];

  task automatic expect_at(input int at, input logic v, input string tag);
    item_t it;
    it.at = at; it.exp_n = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops scoreboard items whose cycle has arrived
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      automatic item_t it = q.pop_front();
      checks++;
      if (it.at != cyc || rst_out_n !== it.exp_n) begin
        errors++;
        $display("FAIL %s cycle %0d: rst_out_n=%b expected %b (item cycle %0d)",
                 it.tag, cyc, rst_out_n, it.exp_n, it.at);
      end
      checks++;
      if (rst_out !== ~it.exp_n) begin
        errors++;
        $display("FAIL R8 cycle %0d: rst_out=%b expected %b", cyc, rst_out, ~it.exp_n);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
    report();
  end

  initial begin
    int n0, t, a, r, r2, x, r3, r4;
    rst_n = 1'b0; supply_low = 1'b0; wd_in = 1'b0; wd_off = 1'b1;
    repeat (3) @(negedge clk);
    // R9: state while block reset is held
    checks++;
    if (rst_out_n !== 1'b0 || rst_out !== 1'b1) begin
      errors++;
      $display("FAIL R9: rst_out_n=%b rst_out=%b expected 0 1", rst_out_n, rst_out);
    end
    n0 = cyc;
    expect_at(n0 + R - 1, 1'b0, "R9");
    expect_at(n0 + R,     1'b1, "R9");
    rst_n = 1'b1;

    // R1/R2: dip of five sampled edges
    wait_cyc(n0 + R + 5);
    t = cyc;
    expect_at(t + 1,         1'b0, "R1");
    expect_at(t + 5,         1'b0, "R1");
    expect_at(t + 5 + R - 1, 1'b0, "R2");
    expect_at(t + 5 + R,     1'b1, "R2");
    supply_low = 1'b1;
    wait_cyc(t + 5);
    supply_low = 1'b0;

    // R3: second dip during the hold restarts it
    wait_cyc(t + 5 + R + 5);
    a = cyc;
    r = a + 13 + R;
    expect_at(a + 1,      1'b0, "R3");
    expect_at(a + 2 + R,  1'b0, "R3");
    expect_at(r - 1,      1'b0, "R3");
    expect_at(r,          1'b1, "R3");
    // R4: expiry after release with no kicks
    expect_at(r + W - 1,     1'b1, "R4");
    expect_at(r + W,         1'b0, "R4");
    expect_at(r + W + R - 1, 1'b0, "R4");
    expect_at(r + W + R,     1'b1, "R4");
    supply_low = 1'b1;
    wait_cyc(a + 2);
    supply_low = 1'b0;
    wait_cyc(a + 12);
    supply_low = 1'b1;
    wait_cyc(a + 13);
    supply_low = 1'b0;
    wait_cyc(a + 14);
    wd_off = 1'b0;

    // R5: kicks on both edges every 30 cycles keep reset released
    r2 = r + W + R;
    wait_cyc(r2 + 1);
    x = r2 + 143 + W;
    for (int k = 0; k < 5; k++) expect_at(r2 + 21 + 30 * k, 1'b1, "R5");
    expect_at(x - 1, 1'b1, "R5");
    expect_at(x,     1'b0, "R5");
    r3 = x + R;
    expect_at(r3 - 1,     1'b0, "R6");
    expect_at(r3,         1'b1, "R6");
    expect_at(r3 + W - 1, 1'b1, "R6");
    expect_at(r3 + W,     1'b0, "R6");
    for (int k = 0; k < 5; k++) begin
      wait_cyc(r2 + 20 + 30 * k);
      wd_in = ~wd_in;
    end

    // R6: a change during the hold has no effect
    wait_cyc(x + 2);
    wd_in = ~wd_in;

    // R7: disabled watchdog never expires
    r4 = r3 + W + R;
    wait_cyc(r3 + W + 1);
    expect_at(r4,         1'b1, "R7");
    expect_at(r4 + W,     1'b1, "R7");
    expect_at(r4 + W + 1, 1'b1, "R7");
    expect_at(r4 + 3 * W, 1'b1, "R7");
    wait_cyc(r4 + 5);
    wd_off = 1'b1;
    wait_cyc(r4 + 3 * W + 2);
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    report();
  end
endmodule